// File: doc/BRIEF.md
# Cascadable Serial Command and Fault Shifter

This block is the serial control port of a four-channel low-side gate controller. A host frames each transfer with an active-low chip select. While the frame is open, the host moves on/off commands in on a serial data line under a serial clock, and reads per-channel load-fault bits back on a serial data output. At the opening edge of chip select the block takes a snapshot of the fault inputs and presents the top fault bit. Each serial clock rising edge samples one command bit into the bottom of a shift register. Each falling edge moves the data output on by one bit. Once the four fault bits have gone out, the output carries the earlier command bits, so several blocks can be chained with four bits per block in one frame.

At the closing edge of chip select the last four bits shifted in are committed to a command register, and the data output is released. Each channel's gate enable is the OR of its committed command bit and a real-time parallel input, so a fast controller can drive a channel directly without opening a frame. The serial clock, chip select and data line are asynchronous to the system clock. They pass through synchronizers and are edge-detected on the system clock. The tri-state data pin is modelled as a data line plus an active-high output enable.

Top module: `chan_cmd_shifter`

## Requirements
- R1: When chip select falls, the fault vector present at that moment is captured. The output enable is asserted and the data output shows fault bit 3, three system clocks after the chip-select change reaches the input.
- R2: Changes on the fault inputs while chip select stays low do not alter the bits shifted out or the committed commands of that frame.
- R3: On each serial clock rising edge the data input enters bit 0 of the shift register. On each falling edge the data output takes the current bit 3. The output therefore carries faults 3, 2, 1, 0 and then the bits shifted in earlier, first-sent first.
- R4: When chip select rises, the shift register is copied to the command register and the output enable drops. After four clocks, the first bit sent lands on channel 3 and the last on channel 0.
- R5: With fewer than four serial clocks in a frame, the fault bits that were not shifted out are committed as commands. With k clocks, the command is fault bits 3-k down to 0 followed by the k data bits.
- R6: Frames longer than four bits are accepted, and only the final four bits shifted in become commands.
- R7: Gate enable bit i equals command bit i OR parallel input bit i. A command bit of 1 means on, and the parallel path is combinational.
- R8: While reset is low, every gate enable and the output enable are 0. Reset clears the command register, so gates stay off after release until commanded.
- R9: Serial clock edges while chip select is high change neither the command register, the gate enables nor the output enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select, idles high |
| sdi | input | 1 | Serial command data in |
| fault_in | input | NCH | Per-channel load-fault flags, 1 = fault |
| par_in | input | NCH | Real-time parallel channel enables |
| sdo | output | 1 | Serial fault and pass-through data out |
| sdo_oe | output | 1 | Drive enable for the data output pad |
| gate_en | output | NCH | Per-channel gate enable |

## Verification
Every serial pin crosses two synchronizer flops and an edge detector before it acts. So a change on chip select or the serial clock becomes visible at the outputs on the third system-clock rising edge after it is applied. The parallel inputs reach the gate enables within the same cycle. The bench drives pins on the falling system-clock edge. One directed check samples the output enable after exactly two and after three edges to pin the latency down. Every other serial phase is held four system clocks before outputs are sampled. Gate enables are sampled one time unit after a parallel input changes.

// File: rtl/csh_pkg.sv
package csh_pkg;
  // Synchronized level of a serial pin together with its one-cycle edge events.
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } csh_edge_t;
endpackage

// File: rtl/csh_sync.sv
module csh_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/csh_edge_sync.sv
module csh_edge_sync
  import csh_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  output csh_edge_t evt
);
  logic lvl_w;
  logic prev_q;

  csh_sync #(.STAGES(STAGES), .RST_VAL(RST_VAL)) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (din),
    .dout(lvl_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_w;
  end

  assign evt.lvl  = lvl_w;
  assign evt.rise = lvl_w & ~prev_q;
  assign evt.fall = ~lvl_w & prev_q;
endmodule

// File: rtl/csh_frame_shifter.sv
module csh_frame_shifter #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_fall,
  input  logic           cs_rise,
  input  logic           sck_rise,
  input  logic           sck_fall,
  input  logic           sdi_s,
  input  logic [NCH-1:0] fault_in,
  output logic [NCH-1:0] sh_q,
  output logic           sdo_q,
  output logic           active_q,
  output logic           commit
);
  localparam int TOP = NCH - 1;

  // New bits enter at bit 0; bit TOP is the next one out.
  function automatic logic [NCH-1:0] f_shift(input logic [NCH-1:0] cur, input logic b);
    return {cur[TOP-1:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      sdo_q    <= 1'b0;
      active_q <= 1'b0;
    end else if (cs_fall) begin
      sh_q     <= fault_in;
      sdo_q    <= fault_in[TOP];
      active_q <= 1'b1;
    end else if (cs_rise) begin
      sdo_q    <= 1'b0;
      active_q <= 1'b0;
    end else if (active_q) begin
      if (sck_rise) sh_q  <= f_shift(sh_q, sdi_s);
      if (sck_fall) sdo_q <= sh_q[TOP];
    end
  end

  assign commit = cs_rise & active_q;
endmodule

// File: rtl/csh_gate_stage.sv
module csh_gate_stage #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic [NCH-1:0] commit_val,
  input  logic [NCH-1:0] par_in,
  output logic [NCH-1:0] cmd_q,
  output logic [NCH-1:0] gate_en
);
  function automatic logic f_gate(input logic cmd, input logic par, input logic run);
    return run & (cmd | par);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (commit) cmd_q <= commit_val;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign gate_en[i] = f_gate(cmd_q[i], par_in[i], rst_n);
  end
endmodule

// File: rtl/chan_cmd_shifter.sv
module chan_cmd_shifter
  import csh_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk,
  input  logic           cs_n,
  input  logic           sdi,
  input  logic [NCH-1:0] fault_in,
  input  logic [NCH-1:0] par_in,
  output logic           sdo,
  output logic           sdo_oe,
  output logic [NCH-1:0] gate_en
);
  csh_edge_t cs_evt;
  csh_edge_t sck_evt;
  logic      sdi_s;

  // Named internal events, brought out for the checker.
  logic           cs_fall_w;
  logic           cs_rise_w;
  logic           sck_rise_w;
  logic           sck_fall_w;
  logic           commit_w;
  logic [NCH-1:0] sh_w;
  logic [NCH-1:0] cmd_w;
  logic           sdo_w;
  logic           active_w;
  logic           cs_lvl_unused;
  logic           sck_lvl_unused;

  csh_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .evt(cs_evt)
  );

  csh_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk), .evt(sck_evt)
  );

  csh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
    .clk(clk), .rst_n(rst_n), .din(sdi), .dout(sdi_s)
  );

  assign cs_fall_w      = cs_evt.fall;
  assign cs_rise_w      = cs_evt.rise;
  assign cs_lvl_unused  = cs_evt.lvl;
  assign sck_rise_w     = sck_evt.rise;
  assign sck_fall_w     = sck_evt.fall;
  assign sck_lvl_unused = sck_evt.lvl;

  csh_frame_shifter #(.NCH(NCH)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_fall (cs_fall_w),
    .cs_rise (cs_rise_w),
    .sck_rise(sck_rise_w),
    .sck_fall(sck_fall_w),
    .sdi_s   (sdi_s),
    .fault_in(fault_in),
    .sh_q    (sh_w),
    .sdo_q   (sdo_w),
    .active_q(active_w),
    .commit  (commit_w)
  );

  csh_gate_stage #(.NCH(NCH)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit_w),
    .commit_val(sh_w),
    .par_in    (par_in),
    .cmd_q     (cmd_w),
    .gate_en   (gate_en)
  );

  assign sdo    = sdo_w;
  assign sdo_oe = active_w;
endmodule

// File: rtl/csh_checker.sv
module csh_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_fall,
  input logic           cs_rise,
  input logic           sck_rise,
  input logic           sck_fall,
  input logic           sdo,
  input logic           sdo_oe,
  input logic [NCH-1:0] fault_in,
  input logic [NCH-1:0] sh_q,
  input logic [NCH-1:0] cmd_q,
  input logic [NCH-1:0] par_in,
  input logic [NCH-1:0] gate_en
);
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sdo_oe && sdo == $past(fault_in[NCH-1]) && sh_q == $past(fault_in));

  a_r3_lsb_in: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && sck_rise && !cs_rise) |=> sh_q[NCH-1:1] == $past(sh_q[NCH-2:0]));

  a_r3_sdo_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && sck_fall && !cs_rise) |=> sdo == $past(sh_q[NCH-1]));

  a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && cs_rise) |=> cmd_q == $past(sh_q) && !sdo_oe);

  a_r7_gate_or: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en == (cmd_q | par_in));

  a_r8_reset_off: assert property (@(posedge clk)
    !rst_n |-> gate_en == '0 && !sdo_oe);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && !cs_fall) |=> $stable(cmd_q) && !sdo_oe);
endmodule

bind chan_cmd_shifter csh_checker #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_fall (cs_fall_w),
  .cs_rise (cs_rise_w),
  .sck_rise(sck_rise_w),
  .sck_fall(sck_fall_w),
  .sdo     (sdo),
  .sdo_oe  (sdo_oe),
  .fault_in(fault_in),
  .sh_q    (sh_w),
  .cmd_q   (cmd_w),
  .par_in  (par_in),
  .gate_en (gate_en)
);

// File: tb/chan_cmd_shifter_bench.sv
module chan_cmd_shifter_bench;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic           sclk;
  logic           cs_n;
  logic           sdi;
  logic [NCH-1:0] fault_in;
  logic [NCH-1:0] par_in;
  logic           sdo;
  logic           sdo_oe;
  logic [NCH-1:0] gate_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  chan_cmd_shifter #(.NCH(NCH)) u_chan_cmd_shifter (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .fault_in(fault_in), .par_in(par_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .gate_en(gate_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int c);
    repeat (c) @(negedge clk);
  endtask

  // Frame stream: fault bits first, then sent bits; b bit 0 is the last sent.
  function automatic logic [31:0] stream_vec(input logic [NCH-1:0] f, input logic [15:0] b, input int n);
    logic [31:0] m;
    m = (n == 0) ? 32'd0 : ((32'd1 << n) - 32'd1);
    return (32'(f) << n) | (32'(b) & m);
  endfunction

  function automatic logic stream_bit(input logic [NCH-1:0] f, input logic [15:0] b, input int n, input int k);
    logic [31:0] v;
    v = stream_vec(f, b, n);
    return v[NCH + n - 1 - k];
  endfunction

  function automatic logic [NCH-1:0] exp_cmd(input logic [NCH-1:0] f, input logic [15:0] b, input int n);
    logic [31:0] v;
    v = stream_vec(f, b, n);
    return v[NCH-1:0];
  endfunction

  task automatic frame(input logic [NCH-1:0] f, input logic [15:0] b, input int n, input logic [NCH-1:0] par);
    string tag;
    logic [NCH-1:0] e;
    tag = (n < NCH) ? "R5" : ((n > NCH) ? "R6" : "R4");
    e = exp_cmd(f, b, n);
    fault_in = f;
    par_in   = par;
    hold(2);
    cs_n = 1'b0;
    hold(4);
    chk(sdo_oe == 1'b1, "R1 oe", 32'(sdo_oe), 32'd1);
    chk(sdo == stream_bit(f, b, n, 0), "R1 fault3", 32'(sdo), 32'(stream_bit(f, b, n, 0)));
    fault_in = ~f;  // R2: late faults must not enter this frame
    for (int k = 0; k < n; k++) begin
      sdi = b[n-1-k];
      hold(1);
      sclk = 1'b1;
      hold(4);
      sclk = 1'b0;
      hold(4);
      chk(sdo == stream_bit(f, b, n, k + 1), "R3 sdo order", 32'(sdo), 32'(stream_bit(f, b, n, k + 1)));
    end
    cs_n = 1'b1;
    hold(4);
    chk(sdo_oe == 1'b0, "R4 oe off", 32'(sdo_oe), 32'd0);
    chk(gate_en == (e | par), {tag, " R2 commit"}, 32'(gate_en), 32'(e | par));
  endtask

  initial begin
    logic [NCH-1:0] keep;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    fault_in = '0; par_in = '1;
    hold(3);
    chk(gate_en == '0, "R8 reset gates", 32'(gate_en), 32'd0);
    chk(sdo_oe == 1'b0, "R8 reset oe", 32'(sdo_oe), 32'd0);
    rst_n  = 1'b1;
    par_in = '0;
    hold(4);
    chk(gate_en == '0, "R8 after release", 32'(gate_en), 32'd0);

    // R1 latency: action lands on the third clock edge
    fault_in = 4'b1010;
    hold(2);
    cs_n = 1'b0;
    hold(2);
    chk(sdo_oe == 1'b0, "R1 not before 3 edges", 32'(sdo_oe), 32'd0);
    hold(1);
    chk(sdo_oe == 1'b1 && sdo == 1'b1, "R1 at 3 edges", {30'd0, sdo_oe, sdo}, 32'd3);
    cs_n = 1'b1;
    hold(4);
    chk(gate_en == 4'b1010, "R5 zero clocks", 32'(gate_en), 32'hA);

    frame(4'b0110, 16'h9, 4, 4'b0000);
    // R7: parallel inputs OR into the committed commands
    par_in = 4'b0110;
    #1;
    chk(gate_en == 4'b1111, "R7 or", 32'(gate_en), 32'hF);
    par_in = 4'b0000;
    #1;
    chk(gate_en == 4'b1001, "R7 par low", 32'(gate_en), 32'h9);
    hold(1);

    frame(4'b1100, 16'h2, 2, 4'b0000);   // R5: gives 0010
    frame(4'b1111, 16'hA5, 8, 4'b0000);  // R6 cascade pass-through
    frame(4'b0001, 16'h3C7, 10, 4'b0100);

    // R9: serial clocks while deselected
    keep = gate_en;
    sdi  = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; hold(4);
      sclk = 1'b0; hold(4);
      chk(sdo_oe == 1'b0, "R9 oe idle", 32'(sdo_oe), 32'd0);
      chk(gate_en == keep, "R9 gates held", 32'(gate_en), 32'(keep));
    end

    for (int i = 0; i < 40; i++) begin
      frame(4'($urandom), 16'($urandom), int'($urandom_range(0, 10)), 4'($urandom_range(0, 15) & 4'($urandom)));
    end

    // R8: reset mid-run clears commands
    frame(4'b0000, 16'hF, 4, 4'b0000);
    rst_n = 1'b0;
    hold(1);
    chk(gate_en == '0, "R8 reset mid-run", 32'(gate_en), 32'd0);
    hold(2);
    rst_n = 1'b1;
    hold(4);
    chk(gate_en == '0, "R8 cmd cleared", 32'(gate_en), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule